// File: doc/BRIEF.md
# I2C Slave Register Bank

This block is an I2C bus target that holds eight byte-wide registers. The block oversamples the open-drain SCL and SDA lines with the system clock. It recognises bus START and STOP conditions and takes in an address byte. It claims the transfer when the upper four address bits equal a fixed prefix. The three bits below the prefix pick one register, and the last bit of the address byte gives the direction.

A write transfer stores one data byte into the picked register. A read transfer returns that register's contents, most significant bit first. Before each acknowledge it gives, the block can hold SCL low for a number of system clock cycles set by a 4-bit input. A debug port lets on-chip logic read any register at any time without using the bus.

The bus pins follow open-drain practice. Each `*_oe_o` output set to 1 means "pull the line low", and the pad releases the line when the output is 0.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state and releases SDA. A rising SDA while SCL is high (STOP) returns the block to idle with SDA and SCL both released.
- R2: The address byte is sampled MSB first, one bit per SCL rising edge. Bits [7:4] must equal the prefix parameter (default 4'hA), bits [3:1] select the register, and bit 0 is the direction (1 = read, 0 = write). On a match, the block drives SDA low during the ninth SCL pulse.
- R3: On a prefix mismatch, the block gives no acknowledge and keeps both lines released until the next START. Any data sent in the rest of the transfer leaves every register unchanged.
- R4: On a write, the next byte (MSB first) is stored into the selected register and acknowledged. Any further byte before the next START is neither acknowledged nor stored.
- R5: On a read, the selected register is driven onto SDA MSB first. SDA is released for the master's acknowledge bit, and the block changes SDA only while SCL is low.
- R6: During a read, a master NACK ends the transfer, with SDA released until the next START. A master ACK makes the block send the same register again.
- R7: At the SCL falling edge that ends the eighth bit of an acknowledged byte, the block samples the wait input W. It then holds SCL low for exactly W system clock cycles. When W = 0, SCL is never held.
- R8: After reset, all eight registers read 0x00 and both lines are released.
- R9: The debug port returns the register selected by `dbg_sel_i` combinationally. A bus write becomes visible there from the clock cycle after it commits, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| wait_cycles_i | input | 4 | Stretch length in system clock cycles, 0 disables |
| dbg_sel_i | input | 3 | Register index for the debug read |
| dbg_data_o | output | 8 | Contents of the register picked by dbg_sel_i |

## Verification
Two functions can fall in the same cycle: a bus write committing a byte into a register, and the debug port reading that same register. The bench points the debug select at the target register before a write transfer starts and keeps it there through the acknowledge. It then records every change of the debug output. The write is judged correct only if the debug value changes exactly once, from the old contents to the new byte, and never shows an intermediate value.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // one extra stage holds the previous synchronised value for edge detection
  logic [SYNC_STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[SYNC_STAGES-1:0], line_i};
  end

  assign level_o = q[SYNC_STAGES-1];
  assign rise_o  = q[SYNC_STAGES-1] & ~q[SYNC_STAGES];
  assign fall_o  = ~q[SYNC_STAGES-1] & q[SYNC_STAGES];
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              hold_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i && wait_i != '0) begin
      hold_q <= 1'b1;
      cnt_q  <= wait_i - WAIT_W'(1);
    end else if (hold_q) begin
      if (cnt_q == '0) hold_q <= 1'b0;
      else             cnt_q  <= cnt_q - WAIT_W'(1);
    end
  end

  assign hold_o = hold_q;

  // R7: a hold only begins when a non-zero wait was requested
  a_r7_hold_needs_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> ($past(trig_i) && $past(wait_i) != '0));
  // R7: an expired count releases SCL
  a_r7_hold_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && cnt_q == '0 && !trig_i) |=> !hold_q);
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int REG_AW = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_AW-1:0] rsel_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [REG_AW-1:0] dsel_i,
  output logic [DATA_W-1:0] ddata_o
);
  localparam int NREGS = 1 << REG_AW;

  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && wsel_i == REG_AW'(g))     regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];
  assign ddata_o = regs_q[dsel_i];

  // R4: a committed byte lands in the selected register
  a_r4_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wsel_i)] == $past(wdata_i));
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter int                  PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] PREFIX   = 4'hA,
  parameter int                  REG_AW   = 3,
  parameter int                  DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              sda_oe_o,
  output logic              stretch_o,
  output logic              we_o,
  output logic [REG_AW-1:0] wsel_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [REG_AW-1:0] rsel_o,
  input  logic [DATA_W-1:0] rdata_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [REG_AW-1:0] sel_q;
  logic              rw_q, sda_oe_q, mack_q;

  logic start, stop, match, addr_done, wr_done;

  assign start     = sda_fall_i & scl_s_i;
  assign stop      = sda_rise_i & scl_s_i;
  assign match     = shreg_q[DATA_W-1 -: PREFIX_W] == PREFIX;
  assign addr_done = state_q == ST_ADDR  && scl_fall_i && bitcnt_q == FULL && !start && !stop;
  assign wr_done   = state_q == ST_WDATA && scl_fall_i && bitcnt_q == FULL && !start && !stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      sel_q    <= '0;
      rw_q     <= 1'b0;
      sda_oe_q <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise_i && bitcnt_q != FULL) begin
            shreg_q  <= {shreg_q[DATA_W-2:0], sda_s_i};
            bitcnt_q <= bitcnt_q + CNT_W'(1);
          end else if (scl_fall_i && bitcnt_q == FULL) begin
            if (state_q == ST_WDATA) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_WDATA_ACK;
            end else if (match) begin
              sel_q    <= shreg_q[REG_AW:1];
              rw_q     <= shreg_q[0];
              sda_oe_q <= 1'b1;
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              shreg_q  <= rdata_i;
              sda_oe_q <= ~rdata_i[DATA_W-1];
              bitcnt_q <= CNT_W'(1);
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_WDATA;
            end
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (bitcnt_q == FULL) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RACK;
            end else begin
              sda_oe_q <= ~shreg_q[DATA_W-2];
              shreg_q  <= {shreg_q[DATA_W-2:0], 1'b0};
              bitcnt_q <= bitcnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_q <= ~sda_s_i;
          else if (scl_fall_i) begin
            if (mack_q) begin
              shreg_q  <= rdata_i;
              sda_oe_q <= ~rdata_i[DATA_W-1];
              bitcnt_q <= CNT_W'(1);
              state_q  <= ST_RDATA;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign stretch_o = (addr_done && match) || wr_done;
  assign we_o      = wr_done;
  assign wsel_o    = sel_q;
  assign wdata_o   = shreg_q;
  assign rsel_o    = sel_q;

  // R1: START opens an address phase with SDA released
  a_r1_start_enters_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_ADDR && !sda_oe_q));
  // R1: STOP returns to idle with SDA released
  a_r1_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !start) |=> (state_q == ST_IDLE && !sda_oe_q));
  // R5: SDA is only pulled while SCL is low
  a_r5_pull_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !$past(scl_s_i));
  // R5: SDA is only released while SCL is low, or on a bus condition
  a_r5_release_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_q) |-> (!$past(scl_s_i) || $past(start) || $past(stop)));
  // R3: an address acknowledge requires a prefix match
  a_r3_ack_needs_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_q) && $past(state_q) == ST_ADDR) |-> $past(shreg_q[DATA_W-1 -: PREFIX_W]) == PREFIX);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [3:0] ADDR_PREFIX = 4'hA,
  parameter int         REG_AW      = 3,
  parameter int         DATA_W      = 8,
  parameter int         WAIT_W      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic [REG_AW-1:0] dbg_sel_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int PREFIX_W = DATA_W - REG_AW - 1;

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic stretch, we;
  logic [REG_AW-1:0] wsel, rsel;
  logic [DATA_W-1:0] wdata, rdata;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_slv_fsm #(
    .PREFIX_W(PREFIX_W),
    .PREFIX  (PREFIX_W'(ADDR_PREFIX)),
    .REG_AW  (REG_AW),
    .DATA_W  (DATA_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_s_i(sda_s), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .sda_oe_o, .stretch_o(stretch), .we_o(we),
    .wsel_o(wsel), .wdata_o(wdata), .rsel_o(rsel), .rdata_i(rdata)
  );

  i2c_stretch_ctrl #(.WAIT_W(WAIT_W)) u_stretch (
    .clk_i, .rst_ni, .trig_i(stretch), .wait_i(wait_cycles_i), .hold_o(scl_oe_o)
  );

  i2c_reg_file #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .wsel_i(wsel), .wdata_i(wdata),
    .rsel_i(rsel), .rdata_o(rdata),
    .dsel_i(dbg_sel_i), .ddata_o(dbg_data_o)
  );
endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int HP = 16;
  localparam int QP = 8;
  localparam logic [3:0] PFX = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] wait_c = '0;
  logic [2:0] dbg_sel = '0;
  logic scl_oe, sda_oe;
  logic [7:0] dbg_data;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [8];

  always #4ns clk = ~clk;

  i2c_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .wait_cycles_i(wait_c),
    .dbg_sel_i(dbg_sel), .dbg_data_o(dbg_data)
  );

  // stretch pulse monitor
  int st_cur = 0, st_last = 0, st_pulses = 0;
  always @(posedge clk) begin
    if (scl_oe) st_cur <= st_cur + 1;
    else if (st_cur != 0) begin
      st_last <= st_cur; st_pulses <= st_pulses + 1; st_cur <= 0;
    end
  end

  // SDA must not move while SCL stays high
  int sda_bad = 0;
  logic sda_oe_p = 1'b0, scl_p = 1'b1;
  always @(posedge clk) begin
    if (rst_n && sda_oe != sda_oe_p && scl_line && scl_p) sda_bad <= sda_bad + 1;
    sda_oe_p <= sda_oe; scl_p <= scl_line;
  end

  // debug value change monitor
  bit mon_en = 0;
  int mon_changes = 0;
  logic [7:0] mon_prev = '0;
  always @(negedge clk) begin
    if (mon_en && dbg_data != mon_prev) mon_changes <= mon_changes + 1;
    mon_prev <= dbg_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) wt(1);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt(QP);
    m_scl = 1'b1; wait_scl_high(); wt(HP);
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b0; wt(QP);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt(QP);
    m_scl = 1'b1; wait_scl_high(); wt(HP);
    m_sda = 1'b1; wt(HP);
  endtask

  task automatic clk_bit(input bit b, output bit r);
    m_sda = b; wt(QP);
    m_scl = 1'b1; wait_scl_high(); wt(HP/2);
    r = sda_line; wt(HP/2);
    m_scl = 1'b0; wt(QP);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(~give_ack, r);
  endtask

  function automatic logic [7:0] abyte(input logic [3:0] p, input logic [2:0] idx, input bit rd);
    return {p, idx, rd};
  endfunction

  task automatic chk_stretch(input int w, input int pulses);
    if (w == 0) chk(st_pulses == 0, "R7 no stretch", st_pulses, 0);
    else begin
      chk(st_pulses == pulses, "R7 stretch count", st_pulses, pulses);
      chk(st_last == w, "R7 stretch width", st_last, w);
    end
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [7:0] d, input logic [3:0] w);
    bit ack;
    wait_c = w; st_pulses = 0;
    i2c_start();
    send_byte(abyte(PFX, idx, 1'b0), ack);
    chk(ack, "R2 address ack", ack, 1);
    send_byte(d, ack);
    chk(ack, "R4 data ack", ack, 1);
    chk_stretch(w, 2);
    i2c_stop();
    model[idx] = d;
    dbg_sel = idx; wt(1);
    chk(dbg_data == d, "R4 stored byte", dbg_data, d);
  endtask

  task automatic do_read(input logic [2:0] idx, input logic [3:0] w);
    bit ack;
    logic [7:0] d;
    wait_c = w; st_pulses = 0;
    i2c_start();
    send_byte(abyte(PFX, idx, 1'b1), ack);
    chk(ack, "R2 read address ack", ack, 1);
    recv_byte(d, 1'b0);
    chk(d == model[idx], "R5 read data", d, model[idx]);
    chk_stretch(w, 1);
    i2c_stop();
  endtask

  initial begin
    bit ack, r;
    logic [7:0] d1, d2, d3;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    wt(5); rst_n = 1'b1; wt(3);

    // R8 reset state
    chk(!sda_oe && !scl_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i); wt(1);
      chk(dbg_data == 8'h00, "R8 register reset", dbg_data, 0);
    end

    // directed: no stretch and maximum stretch
    do_write(3'd0, 8'h5A, 4'd0);
    do_write(3'd7, 8'hC3, 4'd15);
    do_read(3'd7, 4'd0);
    do_read(3'd0, 4'd1);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [2:0] idx;
      logic [3:0] w;
      idx = 3'($urandom % 8);
      w   = 4'($urandom % 16);
      if ($urandom % 2 == 0) do_write(idx, 8'($urandom), w);
      else                   do_read(idx, w);
    end

    // R3 prefix mismatch: no ack, data ignored
    wait_c = 4'd3; st_pulses = 0;
    i2c_start();
    send_byte(abyte(4'h5, 3'd2, 1'b0), ack);
    chk(!ack, "R3 no ack on mismatch", ack, 0);
    send_byte(8'hEE, ack);
    chk(!ack, "R3 data not acked", ack, 0);
    chk(st_pulses == 0, "R3 no stretch on mismatch", st_pulses, 0);
    i2c_stop();
    dbg_sel = 3'd2; wt(1);
    chk(dbg_data == model[2], "R3 register unchanged", dbg_data, model[2]);

    // R4 extra byte after a write is ignored
    wait_c = 4'd0;
    i2c_start();
    send_byte(abyte(PFX, 3'd4, 1'b0), ack);
    send_byte(8'h71, ack);
    chk(ack, "R4 first byte ack", ack, 1);
    send_byte(8'h9F, ack);
    chk(!ack, "R4 extra byte not acked", ack, 0);
    i2c_stop();
    model[4] = 8'h71;
    dbg_sel = 3'd4; wt(1);
    chk(dbg_data == 8'h71, "R4 extra byte not stored", dbg_data, 8'h71);

    // R6 master ACK repeats the register, NACK ends the transfer
    i2c_start();
    send_byte(abyte(PFX, 3'd4, 1'b1), ack);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b0);
    recv_byte(d3, 1'b0);
    chk(d1 == 8'h71, "R6 first read byte", d1, 8'h71);
    chk(d2 == 8'h71, "R6 repeated byte after ACK", d2, 8'h71);
    chk(d3 == 8'hFF, "R6 SDA released after NACK", d3, 8'hFF);
    i2c_stop();

    // R1 repeated START inside an address byte, then a normal write
    i2c_start();
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
    i2c_start();
    send_byte(abyte(PFX, 3'd6, 1'b0), ack);
    chk(ack, "R1 ack after repeated START", ack, 1);
    send_byte(8'h3C, ack);
    i2c_stop();
    model[6] = 8'h3C;
    chk(!sda_oe && !scl_oe, "R1 lines released after STOP", {scl_oe, sda_oe}, 0);
    dbg_sel = 3'd6; wt(1);
    chk(dbg_data == 8'h3C, "R1 write after repeated START", dbg_data, 8'h3C);

    // R9 debug read of the register being written
    dbg_sel = 3'd6; wt(2);
    mon_changes = 0; mon_en = 1;
    do_write(3'd6, 8'hA5, 4'd5);
    mon_en = 0;
    chk(mon_changes == 1, "R9 single debug transition", mon_changes, 1);
    chk(dbg_data == 8'hA5, "R9 debug shows new byte", dbg_data, 8'hA5);

    // R5 SDA never moved while SCL was high
    chk(sda_bad == 0, "R5 SDA moved with SCL high", sda_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule